// File: doc/BRIEF.md
# Single-Precision Floating-Point Divide Unit

This unit divides one IEEE-754 single-precision operand (the dividend) by another (the divisor) over a fixed number of clock cycles. Each operand is first sorted into a class. The classes are signalling NaN, quiet NaN, normal, infinity, zero and denormal. Operand pairs that need special handling are settled by a fixed priority order. Pairs of two normal operands go to a radix-4 restoring mantissa divider, and the quotient is rounded to nearest, ties to even.

Each operation also produces a six-bit exception cause vector and a set of sticky flags. A five-bit trap-enable mask is sampled with the operands. When the outcome must trap, the unit raises a trap request and keeps the destination write strobe low. The cause and flag outputs still report what happened.

A host pulses `start` with the operands while the unit is idle. It then waits for the one-cycle `valid` pulse. On that pulse it writes `quotient` to its register file if `writeEn` is high, or vectors to a handler if `trapReq` is high.

Top module: `fpDivUnit`

## Requirements
- R1: `valid` pulses for exactly one cycle. It is high after the 14th rising edge counted from the edge that samples `start` while the unit is idle. A `start` that arrives while `busy` is high is ignored. Operands and the enable mask are captured on the start edge.
- R2: `cause` reads zero from the edge after an operation is accepted until its `valid`. After that it holds the new cause until the next start. The cause encoding is: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid, bit5 unimplemented operation.
- R3: A NaN (exponent 255, nonzero fraction) whose fraction bit 22 is set is signalling. If either operand is signalling, the result is the default NaN 0x7FBFFFFF and the cause is invalid only. This holds even when the other operand is a quiet NaN.
- R4: A NaN whose fraction bit 22 is clear is quiet. If neither operand is signalling but one is quiet, the result is 0x7FBFFFFF and the cause is zero.
- R5: If neither operand is a NaN but either one is denormal (exponent 0, nonzero fraction), the cause is unimplemented operation only and the quotient reads 0. This case always traps.
- R6: Infinity divided by zero or by a normal number gives infinity. Zero divided by infinity or by a normal number gives zero. A normal number divided by infinity gives zero. In each case the sign is the XOR of the two operand signs and the cause is zero.
- R7: A normal number divided by zero gives a signed infinity with the divide-by-zero cause. Zero divided by zero and infinity divided by infinity give 0x7FBFFFFF with the invalid cause.
- R8: Two normal operands give the quotient rounded to nearest, ties to even. The inexact cause is set exactly when the quotient is not exact.
- R9: The result overflows when the rounded biased exponent is 255 or more. It then becomes a signed infinity with the overflow and inexact causes. The result underflows when the rounded biased exponent is 0 or less. It then becomes a signed zero with the underflow and inexact causes.
- R10: Mask bit k of `trapEnable` (k = 0..4) enables a trap for cause bit k. `trapReq` pulses with `valid` when an enabled cause is set or when the unimplemented cause is set. It also pulses on every operation while bit 0 (inexact) of the mask is set.
- R11: `writeEn` pulses with `valid` only when `trapReq` is low. Bits 4..0 of `flags` accumulate the OR of every cause reported since reset, including those of trapped operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| dividend | input | 32 | Dividend operand, single precision |
| divisor | input | 32 | Divisor operand, single precision |
| trapEnable | input | 5 | Per-cause trap enable mask |
| busy | output | 1 | Operation in progress |
| valid | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result of the last operation |
| cause | output | 6 | Cause bits of the last operation |
| flags | output | 5 | Sticky accumulated cause bits |
| trapReq | output | 1 | Trap request, pulses with valid |
| writeEn | output | 1 | Destination write strobe, pulses with valid |

## Verification
Two things are decided in the same finishing cycle: the trap decision and the write strobe, and both must agree with the sticky flag update made at that edge. The case where they most easily disagree is an exact quotient computed while the inexact enable is set. This is provoked with exact divides such as 6/3 under that mask. The check looks for a trap with no write and with no inexact flag added. A second start pulse is also driven in the middle of an operation. It collides with the iteration steps, and the first operation's result and 14-cycle timing must come out unchanged, with no second `valid`.

// File: rtl/fpDivPkg.sv
package fpDivPkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;
  localparam int CAUSE_W = 6;
  localparam int CI = 0;  // inexact
  localparam int CU = 1;  // underflow
  localparam int CO = 2;  // overflow
  localparam int CZ = 3;  // divide by zero
  localparam int CV = 4;  // invalid
  localparam int CE = 5;  // unimplemented
  localparam logic [31:0] DEFAULT_NAN = 32'h7FBF_FFFF;

  typedef enum logic [2:0] {
    CLS_SNAN, CLS_QNAN, CLS_NORM, CLS_INF, CLS_ZERO, CLS_DENORM
  } opClass_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } dpStrobe_t;

  function automatic opClass_t classify(input logic [31:0] x);
    if (x[30:23] == '1) begin
      if (x[22:0] == '0) return CLS_INF;
      return x[22] ? CLS_SNAN : CLS_QNAN;
    end
    if (x[30:23] == '0) return (x[22:0] == '0) ? CLS_ZERO : CLS_DENORM;
    return CLS_NORM;
  endfunction
endpackage

// File: rtl/fpDivCtrl.sv
module fpDivCtrl
  import fpDivPkg::*;
#(
  parameter int ITER = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output logic      busy,
  output logic      valid,
  output dpStrobe_t strobe
);
  localparam int CW = $clog2(ITER + 1);

  logic [CW-1:0] cnt;
  logic busyQ, validQ;

  always_comb begin
    strobe.load   = start & ~busyQ;
    strobe.step   = busyQ & (cnt != '0);
    strobe.finish = busyQ & (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      busyQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.finish;
      if (strobe.load) begin
        cnt   <= CW'(ITER);
        busyQ <= 1'b1;
      end else if (strobe.step) begin
        cnt <= cnt - 1'b1;
      end else if (strobe.finish) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy  = busyQ;
  assign valid = validQ;

  // R1: completion is a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);
  // R1: the unit is idle when it reports completion
  a_r1_idle_at_valid: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> !busyQ);
  // R1: a busy unit never accepts a new load
  a_r1_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && strobe.step |=> busyQ);
endmodule

// File: rtl/fpDivPath.sv
module fpDivPath
  import fpDivPkg::*;
#(
  parameter int BPS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       dividend,
  input  logic [31:0]       divisor,
  input  logic [4:0]        trapEnable,
  output logic [31:0]       quotient,
  output logic [CAUSE_W-1:0] cause,
  output logic [4:0]        flags,
  output logic              trapReq,
  output logic              writeEn
);
  localparam int QW = MANT_W + 2;
  localparam int RW = MANT_W + 1;

  logic [31:0] aQ, bQ, resultQ;
  logic [4:0]  enQ, flagsQ;
  logic [CAUSE_W-1:0] causeQ;
  logic [RW-1:0] remQ, remN, dvs;
  logic [QW-1:0] quoQ, quoN;
  logic stepGe;
  logic trapQ, weQ;

  // iteration: BPS restoring steps per cycle
  assign dvs = {1'b0, 1'b1, bQ[FRAC_W-1:0]};
  always_comb begin
    remN = remQ;
    quoN = quoQ;
    stepGe = 1'b0;
    for (int i = 0; i < BPS; i++) begin
      stepGe = (remN >= dvs);
      quoN = {quoN[QW-2:0], stepGe};
      if (stepGe) remN = remN - dvs;
      remN = {remN[RW-2:0], 1'b0};
    end
  end

  // rounding of the finished quotient
  opClass_t ca, cb;
  logic sgn, hi, guard, sticky, inc, carry;
  logic [MANT_W-1:0] mant;
  logic [MANT_W:0]   mantR;
  logic signed [9:0] expPre, expR;
  logic [CAUSE_W-1:0] causeN;
  logic [31:0] resN;
  logic trapN;

  always_comb begin
    ca     = classify(aQ);
    cb     = classify(bQ);
    sgn    = aQ[31] ^ bQ[31];
    hi     = quoQ[QW-1];
    mant   = hi ? quoQ[QW-1:2] : quoQ[QW-2:1];
    guard  = hi ? quoQ[1] : quoQ[0];
    sticky = (hi & quoQ[0]) | (|remQ);
    inc    = guard & (sticky | mant[0]);
    mantR  = {1'b0, mant} + {{MANT_W{1'b0}}, inc};
    carry  = mantR[MANT_W];
    expPre = $signed({2'b00, aQ[30:23]}) - $signed({2'b00, bQ[30:23]})
             + (hi ? 10'sd127 : 10'sd126);
    expR   = expPre + (carry ? 10'sd1 : 10'sd0);
  end

  // special-pair priority and exception resolution
  always_comb begin
    resN   = '0;
    causeN = '0;
    if (ca == CLS_SNAN || cb == CLS_SNAN) begin
      causeN[CV] = 1'b1;
      resN = DEFAULT_NAN;
    end else if (ca == CLS_QNAN || cb == CLS_QNAN) begin
      resN = DEFAULT_NAN;
    end else if (ca == CLS_DENORM || cb == CLS_DENORM) begin
      causeN[CE] = 1'b1;
    end else if ((ca == CLS_ZERO && cb == CLS_ZERO) || (ca == CLS_INF && cb == CLS_INF)) begin
      causeN[CV] = 1'b1;
      resN = DEFAULT_NAN;
    end else if (ca == CLS_INF) begin
      resN = {sgn, 8'hFF, 23'd0};
    end else if (ca == CLS_ZERO || cb == CLS_INF) begin
      resN = {sgn, 31'd0};
    end else if (cb == CLS_ZERO) begin
      causeN[CZ] = 1'b1;
      resN = {sgn, 8'hFF, 23'd0};
    end else if (expR >= 10'sd255) begin
      causeN[CO] = 1'b1;
      causeN[CI] = 1'b1;
      resN = {sgn, 8'hFF, 23'd0};
    end else if (expR <= 10'sd0) begin
      causeN[CU] = 1'b1;
      causeN[CI] = 1'b1;
      resN = {sgn, 31'd0};
    end else begin
      causeN[CI] = guard | sticky;
      resN = {sgn, expR[7:0], carry ? 23'd0 : mantR[FRAC_W-1:0]};
    end
    trapN = (|(causeN[4:0] & enQ)) | causeN[CE] | enQ[CI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ <= '0; bQ <= '0; enQ <= '0;
      remQ <= '0; quoQ <= '0;
      resultQ <= '0; causeQ <= '0; flagsQ <= '0;
      trapQ <= 1'b0; weQ <= 1'b0;
    end else begin
      trapQ <= strobe.finish & trapN;
      weQ   <= strobe.finish & ~trapN;
      if (strobe.load) begin
        aQ     <= dividend;
        bQ     <= divisor;
        enQ    <= trapEnable;
        remQ   <= {1'b0, 1'b1, dividend[FRAC_W-1:0]};
        quoQ   <= '0;
        causeQ <= '0;
      end else if (strobe.step) begin
        remQ <= remN;
        quoQ <= quoN;
      end else if (strobe.finish) begin
        resultQ <= resN;
        causeQ  <= causeN;
        flagsQ  <= flagsQ | causeN[4:0];
      end
    end
  end

  assign quotient = resultQ;
  assign cause    = causeQ;
  assign flags    = flagsQ;
  assign trapReq  = trapQ;
  assign writeEn  = weQ;

  // R11: sticky flags never lose a set bit
  a_r11_sticky_keep: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & $past(flagsQ)) == $past(flagsQ));
  // R10: inexact enable forces a trap on every completion
  a_r10_inexact_trap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish && enQ[CI] |=> trapQ && !weQ);
  // R2: cause is cleared during the iteration
  a_r2_cause_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> causeQ == '0);
endmodule

// File: rtl/fpDivUnit.sv
module fpDivUnit
  import fpDivPkg::*;
#(
  parameter int BPS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [31:0] divisor,
  input  logic [4:0]  trapEnable,
  output logic        busy,
  output logic        valid,
  output logic [31:0] quotient,
  output logic [5:0]  cause,
  output logic [4:0]  flags,
  output logic        trapReq,
  output logic        writeEn
);
  localparam int ITER = (MANT_W + 2) / BPS;

  dpStrobe_t strobe;

  fpDivCtrl #(.ITER(ITER)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .valid(valid), .strobe(strobe)
  );

  fpDivPath #(.BPS(BPS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dividend(dividend), .divisor(divisor), .trapEnable(trapEnable),
    .quotient(quotient), .cause(cause), .flags(flags),
    .trapReq(trapReq), .writeEn(writeEn)
  );

  // R11: no write on a trapped or non-completing cycle
  a_r11_write_gate: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> valid && !trapReq);
  // R10: outcome strobes only with completion
  a_r10_trap_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> valid);
  // R5: unimplemented operation always traps
  a_r5_denorm_trap: assert property (@(posedge clk) disable iff (!rstN)
    valid && cause[CE] |-> trapReq && !writeEn);
  // R2: cause reads zero once an operation is under way
  a_r2_cause_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cause == '0);
endmodule

// File: tb/sim_fpDivUnit.sv
module sim_fpDivUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [4:0] trapEnable = '0;
  logic busy, valid, trapReq, writeEn;
  logic [31:0] quotient;
  logic [5:0] cause;
  logic [4:0] flags;

  int checks = 0;
  int fails = 0;
  logic [4:0] expFlags = '0;

  always #2.5 clk = ~clk;

  fpDivUnit u0 (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .trapEnable(trapEnable), .busy(busy), .valid(valid),
    .quotient(quotient), .cause(cause), .flags(flags),
    .trapReq(trapReq), .writeEn(writeEn)
  );

  typedef struct packed {
    logic [31:0] res;
    logic [5:0]  cause;
    logic        trap;
  } expect_t;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 norm, 1 zero, 2 inf, 3 denorm, 4 qnan, 5 snan
  function automatic int kind(input logic [31:0] x);
    if (x[30:23] == 8'hFF) return (x[22:0] == 0) ? 2 : (x[22] ? 5 : 4);
    if (x[30:23] == 8'h00) return (x[22:0] == 0) ? 1 : 3;
    return 0;
  endfunction

  function automatic expect_t model(input logic [31:0] a, input logic [31:0] b, input logic [4:0] en);
    expect_t e;
    int ka, kb, ex;
    logic s;
    logic [63:0] num, q, r, m;
    logic g, st, up;
    ka = kind(a); kb = kind(b); s = a[31] ^ b[31];
    e = '0;
    if (ka == 5 || kb == 5) begin e.cause[4] = 1; e.res = 32'h7FBFFFFF; end      // R3
    else if (ka == 4 || kb == 4) e.res = 32'h7FBFFFFF;                             // R4
    else if (ka == 3 || kb == 3) e.cause[5] = 1;                                   // R5
    else if ((ka == 1 && kb == 1) || (ka == 2 && kb == 2)) begin e.cause[4] = 1; e.res = 32'h7FBFFFFF; end // R7
    else if (ka == 2) e.res = {s, 8'hFF, 23'd0};                                   // R6
    else if (ka == 1 || kb == 2) e.res = {s, 31'd0};
    else if (kb == 1) begin e.cause[3] = 1; e.res = {s, 8'hFF, 23'd0}; end
    else begin                                                                     // R8, R9
      num = {15'd0, 1'b1, a[22:0], 25'd0};
      q = num / {40'd0, 1'b1, b[22:0]};
      r = num % {40'd0, 1'b1, b[22:0]};
      ex = int'(a[30:23]) - int'(b[30:23]) + 127;
      if (q[25]) begin m = q >> 2; g = q[1]; st = q[0] | (r != 0); end
      else begin m = q >> 1; g = q[0]; st = (r != 0); ex = ex - 1; end
      up = g & (st | m[0]);
      m = m + up;
      if (m[24]) begin ex = ex + 1; m = m >> 1; end
      if (ex >= 255) begin e.cause[2] = 1; e.cause[0] = 1; e.res = {s, 8'hFF, 23'd0}; end
      else if (ex <= 0) begin e.cause[1] = 1; e.cause[0] = 1; e.res = {s, 31'd0}; end
      else begin e.cause[0] = g | st; e.res = {s, ex[7:0], m[22:0]}; end
    end
    e.trap = (|(e.cause[4:0] & en)) | e.cause[5] | en[0];                          // R10
    return e;
  endfunction

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [4:0] en, input bit midStart);
    expect_t e;
    int n;
    bit extra;
    e = model(a, b, en);
    @(negedge clk);
    dividend = a; divisor = b; trapEnable = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = 32'h3F80_0000; trapEnable = ~en;
    check(busy && cause == 6'd0, "R2 cause cleared at start", {58'd0, cause}, 64'd0);
    n = 1;
    while (!valid && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 4 && midStart) start = 1'b1;
      if (n == 5) start = 1'b0;
    end
    check(n - 1 == 14, "R1 latency", 64'(n - 1), 64'd14);
    check(quotient == e.res, "R3-R9 quotient", {32'd0, quotient}, {32'd0, e.res});
    check(cause == e.cause, "R2 cause", {58'd0, cause}, {58'd0, e.cause});
    check(trapReq == e.trap, "R10 trapReq", {63'd0, trapReq}, {63'd0, e.trap});
    check(writeEn == !e.trap, "R11 writeEn", {63'd0, writeEn}, {63'd0, !e.trap});
    expFlags = expFlags | e.cause[4:0];
    check(flags == expFlags, "R11 sticky flags", {59'd0, flags}, {59'd0, expFlags});
    extra = 0;
    for (int i = 0; i < (midStart ? 20 : 1); i++) begin
      @(negedge clk);
      if (valid || busy) extra = 1;
    end
    if (midStart) check(!extra, "R1 start while busy ignored", {63'd0, extra}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    logic [4:0] en;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!valid && !busy && cause == 0 && flags == 0 && !writeEn && !trapReq,
          "R1 reset state", {31'd0, valid, 21'd0, cause, flags}, 64'd0);
    rstN = 1'b1;
    runOp(32'h40C0_0000, 32'h4040_0000, 5'd0, 1'b0);  // R8 6/3 exact
    runOp(32'h3F80_0000, 32'h4040_0000, 5'd0, 1'b1);  // R8 1/3 inexact, R1 mid-start
    runOp(32'h7FC0_0001, 32'h7F80_0001, 5'd0, 1'b0);  // R3 sNaN over qNaN
    runOp(32'h3F80_0000, 32'h7FC0_0000, 5'd0, 1'b0);  // R3 sNaN divisor
    runOp(32'h7F80_0001, 32'h3F80_0000, 5'd0, 1'b0);  // R4 qNaN
    runOp(32'h0000_0001, 32'h3F80_0000, 5'd0, 1'b0);  // R5 denorm dividend
    runOp(32'h3F80_0000, 32'h8000_0010, 5'd0, 1'b0);  // R5 denorm divisor
    runOp(32'hFF80_0000, 32'h4000_0000, 5'd0, 1'b0);  // R6 -inf/2
    runOp(32'h7F80_0000, 32'h8000_0000, 5'd0, 1'b0);  // R6 inf/-0
    runOp(32'h0000_0000, 32'hC000_0000, 5'd0, 1'b0);  // R6 0/-2
    runOp(32'hC000_0000, 32'h7F80_0000, 5'd0, 1'b0);  // R6 -2/inf
    runOp(32'h4000_0000, 32'h8000_0000, 5'd0, 1'b0);  // R7 2/-0
    runOp(32'h0000_0000, 32'h0000_0000, 5'd0, 1'b0);  // R7 0/0
    runOp(32'h7F80_0000, 32'hFF80_0000, 5'd0, 1'b0);  // R7 inf/inf
    runOp(32'h7F7F_FFFF, 32'h3F00_0000, 5'd0, 1'b0);  // R9 overflow
    runOp(32'h0080_0000, 32'h4000_0000, 5'd0, 1'b0);  // R9 underflow
    runOp(32'h40C0_0000, 32'h4040_0000, 5'b00001, 1'b0); // R10 inexact enable on exact result
    runOp(32'h7F7F_FFFF, 32'h3F00_0000, 5'b00100, 1'b0); // R10 overflow trap suppresses write
    runOp(32'h4000_0000, 32'h0000_0000, 5'b01000, 1'b0); // R10 divide-by-zero trap
    runOp(32'h4000_0000, 32'h4000_0000, 5'b11110, 1'b0); // R11 exact, no trap, write
    for (int k = 0; k < 400; k++) begin
      a = $urandom; b = $urandom;
      if (k % 4 != 0) begin
        a[30:23] = 8'(100 + $urandom % 56);
        b[30:23] = 8'(100 + $urandom % 56);
      end else begin
        a[30:23] = 8'(1 + $urandom % 254);
        b[30:23] = 8'(1 + $urandom % 254);
      end
      if (k % 37 == 0) b[22:0] = 23'd0;
      en = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      runOp(a, b, en, 1'b0);
    end
    for (int k = 0; k < 36; k++) begin
      logic [31:0] pick [6];
      pick[0] = 32'h3FC0_0000; pick[1] = 32'h8000_0000; pick[2] = 32'h7F80_0000;
      pick[3] = 32'h0040_0000; pick[4] = 32'h7F80_0100; pick[5] = 32'hFFC0_0000;
      runOp(pick[k / 6], pick[k % 6], 5'd0, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule